// File: doc/BRIEF.md
# Display Link Training Retry Sequencer

This controller brings up a multi-lane display link transmitter. It updates a 32-bit transmitter control word, which holds the enable, PLL enable, auto-train enable, drive-strength and training-pattern fields. It works with a receiver-side training agent through a single request/done handshake that carries a 3-bit command. A start pulse begins a run. The run ends with a one-cycle done pulse and a success flag that holds until the next start.

There are three flows, chosen by the mode value that is sampled at start:

- **Simple:** one pass through pattern 1, pattern 2 and the final check. Drive strength stays at zero and there is no retry.
- **Full two-phase:** pattern 1 then pattern 2 on each attempt. It walks a four-entry drive-strength table and gives each entry two attempts before moving on.
- **Auto:** each attempt hands training to the receiver hardware. The sequencer then polls a completion flag a bounded number of times, spaced about one microsecond apart.

Failed attempts tear the transmitter down and ask the receiver to power off. If no attempt succeeds, the PLL is dropped and the receiver is asked to stop its clock.

Top module: `link_train_seq`

## Requirements
- R1: After reset, tx_ctl is zero and busy, done, success and rx_req are all low.
- R2: start is accepted only when busy is low. A start pulse during a run does not change the run's sequence of requests or its result.
- R3: An accepted start sets tx_ctl bit 14 (PLL enable) and loads pattern 1 into tx_ctl[9:8]. The pattern codes are: 0 = pattern 1, 1 = pattern 2, 2 = idle, 3 = normal.
- R4: In full and auto modes, attempt n (counting from 0, up to 8 attempts) sets tx_ctl bit 31 and sets tx_ctl[27:22] to entry n/2 of the table {0x00, 0x3A, 0x39, 0x38}. Each entry is therefore tried twice.
- R5: Full mode (mode=1) handles requests as follows:
  - It requests command 0 (pattern-1 training) with pattern code 0 in tx_ctl[9:8].
  - On a pass, it requests command 1 (pattern-2 training) with pattern code 1.
  - On that pass, it requests command 2 (final check) with pattern code 3.
  - success equals rx_pass on that final check.
- R6: After a failed attempt, the sequencer clears tx_ctl bits 31 and 10 and sets tx_ctl[9:8] to 0. It then requests command 3 (receiver off) before the next attempt starts.
- R7: If the last attempt fails, the sequencer clears tx_ctl bit 14, requests command 4 (receiver clock off), and then ends with success low.
- R8: Simple mode (mode=0 or 3) makes a single attempt with tx_ctl[27:22] at zero. If that attempt fails, it issues command 3 and then command 4 and ends with success low.
- R9: Auto mode (mode=2) behaves as follows:
  - It sets tx_ctl bit 10 with pattern code 0 and requests command 6.
  - After that handshake it samples auto_done up to 4 times, with polls spaced CYC_PER_US+1 cycles apart.
  - If auto_done is seen high, it requests command 5 (error-correction enable) and ends with success high.
- R10: busy rises on the cycle after an accepted start and falls in the cycle where done pulses. done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (honoured only when idle) |
| mode | input | 2 | Flow select: 0 simple, 1 full, 2 auto, 3 simple |
| auto_done | input | 1 | Receiver hardware training-complete flag, polled in auto mode |
| rx_done | input | 1 | One-cycle completion of the current receiver request |
| rx_pass | input | 1 | Pass/fail of a training request, valid with rx_done |
| rx_req | output | 1 | Request to the receiver agent is pending |
| rx_cmd | output | 3 | Command of the pending request |
| tx_ctl | output | 32 | Transmitter control word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | Result of the last run |

## Verification
A start sampled at an edge makes busy high after that edge. The first request appears one edge later. A request's next command, or the end of the run, is visible right after the edge that samples rx_done. In auto mode, a run that fails polling shows its receiver-off request 3*(CYC_PER_US+1)+2 edges after the edge at which the bench raised rx_done for the auto-train command; the bench measures exactly that interval. The bench drives inputs and samples outputs on falling edges, so every value it reads has settled after the rising edge that produced it.

// File: rtl/link_train_seq.sv
module link_train_seq #(
  parameter int CYC_PER_US = 100,
  parameter int TRIES      = 2,
  parameter int POLLS      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        auto_done,
  input  logic        rx_done,
  input  logic        rx_pass,
  output logic        rx_req,
  output logic [2:0]  rx_cmd,
  output logic [31:0] tx_ctl,
  output logic        busy,
  output logic        done,
  output logic        success
);
  localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;
  localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;
  localparam int UW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [TW-1:0] TRY_LAST  = TW'(TRIES - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLLS - 1);
  localparam logic [UW-1:0] US_LAST   = UW'(CYC_PER_US - 1);

  localparam int B_TXEN = 31, B_PLL = 14, B_AUTO = 10;

  localparam logic [2:0] C_TP1 = 3'd0, C_TP2 = 3'd1, C_CHK = 3'd2, C_RXOFF = 3'd3,
                         C_CLKOFF = 3'd4, C_EC = 3'd5, C_AUTO = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_ATT, S_RX, S_POLL, S_WAIT} st_t;

  st_t           st;
  logic [1:0]    mode_r, pair;
  logic [TW-1:0] tries;
  logic [PW-1:0] poll;
  logic [UW-1:0] us;
  logic [2:0]    cmd;
  logic [31:0]   tx;
  logic          done_r, succ_r;

  wire is_full = (mode_r == 2'd1);
  wire is_auto = (mode_r == 2'd2);
  wire last_att = !(is_full || is_auto) || (pair == 2'd3 && tries == TRY_LAST);

  function automatic logic [5:0] vp_of(input logic [1:0] i);
    case (i)
      2'd0: vp_of = 6'h00;
      2'd1: vp_of = 6'h3A;
      2'd2: vp_of = 6'h39;
      default: vp_of = 6'h38;
    endcase
  endfunction

  assign rx_req  = (st == S_RX);
  assign rx_cmd  = cmd;
  assign tx_ctl  = tx;
  assign busy    = (st != S_IDLE);
  assign done    = done_r;
  assign success = succ_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_r <= '0; pair <= '0; tries <= '0; poll <= '0; us <= '0;
      cmd <= C_TP1; tx <= '0; done_r <= 1'b0; succ_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_r <= mode; pair <= '0; tries <= '0; succ_r <= 1'b0;
          tx <= '0; tx[B_PLL] <= 1'b1;
          st <= S_ATT;
        end
        S_ATT: begin
          tx[B_TXEN]  <= 1'b1;
          tx[27:22]   <= (is_full || is_auto) ? vp_of(pair) : 6'h00;
          tx[B_AUTO]  <= is_auto;
          tx[9:8]     <= 2'd0;
          cmd <= is_auto ? C_AUTO : C_TP1;
          st  <= S_RX;
        end
        S_RX: if (rx_done) begin
          case (cmd)
            C_TP1, C_TP2: if (rx_pass) begin
              tx[9:8] <= (cmd == C_TP1) ? 2'd1 : 2'd3;
              cmd     <= (cmd == C_TP1) ? C_TP2 : C_CHK;
            end else begin
              tx[B_TXEN] <= 1'b0; tx[B_AUTO] <= 1'b0; tx[9:8] <= 2'd0;
              cmd <= C_RXOFF;
            end
            C_CHK:    begin succ_r <= rx_pass; done_r <= 1'b1; st <= S_IDLE; end
            C_AUTO:   begin poll <= '0; st <= S_POLL; end
            C_RXOFF:  if (last_att) begin
              tx[B_PLL] <= 1'b0; cmd <= C_CLKOFF;
            end else begin
              if (tries == TRY_LAST) begin tries <= '0; pair <= pair + 2'd1; end
              else tries <= tries + 1'b1;
              st <= S_ATT;
            end
            C_CLKOFF: begin succ_r <= 1'b0; done_r <= 1'b1; st <= S_IDLE; end
            default:  begin succ_r <= 1'b1; done_r <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_POLL: if (auto_done) begin
          cmd <= C_EC; st <= S_RX;
        end else if (poll == POLL_LAST) begin
          tx[B_TXEN] <= 1'b0; tx[B_AUTO] <= 1'b0; tx[9:8] <= 2'd0;
          cmd <= C_RXOFF; st <= S_RX;
        end else begin
          us <= '0; st <= S_WAIT;
        end
        S_WAIT: if (us == US_LAST) begin
          poll <= poll + 1'b1; st <= S_POLL;
        end else us <= us + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_train_seq_chk.sv
module link_train_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       success,
  input logic       rx_req,
  input logic [2:0] rx_cmd,
  input logic       tx_en,
  input logic       pll_en,
  input logic       auto_en,
  input logic [1:0] pat
);
  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  rxoff_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd3) |-> (!tx_en && !auto_en && pat == 2'd0));
  // R7
  clkoff_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd4) |-> !pll_en);
  // R5
  tp2_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd1) |-> (tx_en && pat == 2'd1));
  // R5
  final_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd2) |-> (tx_en && pat == 2'd3));
  // R9
  auto_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd6) |-> (tx_en && auto_en && pat == 2'd0));
  // R3
  tp1_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_cmd == 3'd0) |-> (tx_en && pll_en && pat == 2'd0));
  // R7
  ok_keeps_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && success) |-> pll_en);
endmodule

bind link_train_seq link_train_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .success(success), .rx_req(rx_req), .rx_cmd(rx_cmd),
  .tx_en(tx_ctl[31]), .pll_en(tx_ctl[14]), .auto_en(tx_ctl[10]), .pat(tx_ctl[9:8])
);

// File: tb/link_train_seq_test.sv
module link_train_seq_test;
  localparam int CYC = 4;
  localparam int NV  = 13;
  // {mode, nfail, fail_in_tp2, final_pass, exp_success, exp_requests}
  localparam logic [14:0] VEC [NV] = '{
    {2'd1, 4'd0, 1'b0, 1'b1, 1'b1, 6'd3},
    {2'd1, 4'd3, 1'b0, 1'b1, 1'b1, 6'd9},
    {2'd1, 4'd5, 1'b1, 1'b1, 1'b1, 6'd18},
    {2'd1, 4'd8, 1'b0, 1'b1, 1'b0, 6'd17},
    {2'd1, 4'd8, 1'b1, 1'b1, 1'b0, 6'd25},
    {2'd1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd3},
    {2'd0, 4'd0, 1'b0, 1'b1, 1'b1, 6'd3},
    {2'd0, 4'd1, 1'b0, 1'b1, 1'b0, 6'd3},
    {2'd3, 4'd1, 1'b1, 1'b1, 1'b0, 6'd4},
    {2'd2, 4'd0, 1'b0, 1'b1, 1'b1, 6'd2},
    {2'd2, 4'd2, 1'b0, 1'b1, 1'b1, 6'd6},
    {2'd2, 4'd7, 1'b0, 1'b1, 1'b1, 6'd16},
    {2'd2, 4'd8, 1'b0, 1'b1, 1'b0, 6'd17}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, auto_done = 1'b0, rx_done = 1'b0, rx_pass = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rx_req, busy, done, success;
  logic [2:0] rx_cmd;
  logic [31:0] tx_ctl;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_train_seq #(.CYC_PER_US(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .auto_done(auto_done),
    .rx_done(rx_done), .rx_pass(rx_pass), .rx_req(rx_req), .rx_cmd(rx_cmd),
    .tx_ctl(tx_ctl), .busy(busy), .done(done), .success(success)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] vp_exp(input int idx);
    case (idx)
      0: vp_exp = 6'h00;
      1: vp_exp = 6'h3A;
      2: vp_exp = 6'h39;
      default: vp_exp = 6'h38;
    endcase
  endfunction

  task automatic run_vec(input logic [14:0] v);
    logic [1:0] m = v[14:13];
    int nfail = int'(v[12:9]);
    bit ph = v[8], fpass = v[7], esucc = v[6];
    int ereq = int'(v[5:0]);
    bit fullish = (m == 2'd1) || (m == 2'd2);
    int k = 0, cur = 0, reqs = 0, guard = 0, tstamp = 0;
    logic [2:0] last = 3'd7, c;
    bit first = 1'b1, fin = 1'b0, pass;
    auto_done = 1'b0;
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0; mode = ~m;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    chk(tx_ctl[14] == 1'b1, "R3 pll enable on start", tx_ctl[14], 1);
    while (!fin) begin
      @(negedge clk); guard++;
      if (rx_done) rx_done = 1'b0;
      if (guard > 3000) begin
        chk(1'b0, "watchdog", guard, 0);
        fin = 1'b1;
      end else if (done) begin
        fin = 1'b1;
        chk(busy == 1'b0, "R10 busy low at done", busy, 0);
        chk(success == esucc, "R5/R7/R8/R9 result", success, esucc);
        chk(reqs == ereq, "R2 request count", reqs, ereq);
        chk(tx_ctl[14] == (esucc || (nfail == 0)), "R7 pll at end", tx_ctl[14], esucc || (nfail == 0));
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        chk(success == esucc, "R10 success held", success, esucc);
      end else if (rx_req) begin
        reqs++;
        c = rx_cmd;
        pass = 1'b1;
        case (c)
          3'd0, 3'd6: begin
            cur = k; k++;
            chk(tx_ctl[27:22] == (fullish ? vp_exp(cur / 2) : 6'h00), "R4/R8 swing field",
                tx_ctl[27:22], fullish ? vp_exp(cur / 2) : 6'h00);
            chk(tx_ctl[31] && tx_ctl[9:8] == 2'd0, "R4 enable with pattern1", tx_ctl[31:8], 0);
            if (c == 3'd6) begin
              chk(m == 2'd2 && tx_ctl[10], "R9 auto enable", tx_ctl[10], 1);
              auto_done = (cur >= nfail);
            end else begin
              chk(m != 2'd2 && !tx_ctl[10], "R5 no auto enable", tx_ctl[10], 0);
              pass = !(cur < nfail && !ph);
            end
          end
          3'd1: begin
            chk(tx_ctl[9:8] == 2'd1, "R5 pattern2 code", tx_ctl[9:8], 1);
            pass = !(cur < nfail);
          end
          3'd2: begin
            chk(tx_ctl[9:8] == 2'd3, "R5 normal code", tx_ctl[9:8], 3);
            pass = fpass;
          end
          3'd3: begin
            chk(!tx_ctl[31] && !tx_ctl[10] && tx_ctl[9:8] == 2'd0, "R6 teardown", tx_ctl, 0);
            if (last == 3'd6)
              chk(cyc - tstamp == 3 * (CYC + 1) + 2, "R9 poll window", cyc - tstamp, 3 * (CYC + 1) + 2);
            auto_done = 1'b0;
          end
          3'd4: chk(!tx_ctl[14] && (cur == 7 || !fullish), "R7/R8 clock off", tx_ctl[14], 0);
          3'd5: chk(m == 2'd2, "R9 error-correction request", m, 2);
          default: chk(1'b0, "R5 command code", c, 0);
        endcase
        last = c;
        if (first) begin
          start = 1'b1; @(negedge clk); start = 1'b0; first = 1'b0;
        end else @(negedge clk);
        rx_done = 1'b1; rx_pass = pass; tstamp = cyc;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(tx_ctl == 32'h0 && !busy && !done && !success && !rx_req, "R1 reset state", tx_ctl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rx_req, "R1 idle after reset", busy, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R2: start while busy is ignored; run again after a pulse mid-run on a fresh run
    run_vec({2'd1, 4'd1, 1'b0, 1'b1, 1'b1, 6'd5});
    // R1: reset during a run returns to idle state
    @(negedge clk); mode = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx_ctl == 32'h0 && !busy && !rx_req && !success, "R1 reset mid-run", tx_ctl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule